// File: doc/BRIEF.md
# Trigger-Aligned Sample Interpolator

This block sits behind a bank of per-channel filters whose input converter runs at a fixed sample rate. The block makes that stream look as if the converter had sampled at the instant of an asynchronous user trigger. It keeps the latest filtered sample of every channel and measures where the trigger fell inside the sample period. A phase counter clocked by the system clock gives that position in whole clocks. When the next sample arrives, the block draws a straight line between the two samples that bracket the trigger and evaluates it at the trigger's phase. The interpolated word, holding all channels, is pushed into a logging FIFO.

Alongside the logged path, every channel has a live output that holds the most recent filtered value. The live output does not depend on triggers or on the state of the FIFO. The trigger passes through a synchronizer. The sample strobe and the sample data are held back by the same number of clocks, so the measured phase refers to the moment the raw trigger was first sampled. Only one trigger can wait for its closing sample at a time. A trigger that arrives while another is waiting is discarded and sets a sticky flag. A result that finds the FIFO full is discarded and sets a second sticky flag.

Top module: `trig_interp`

## Requirements
- R1: On every clock edge where `smp_stb` is high, `live_data` takes `smp_data` at that edge, whether or not a trigger is waiting and whether or not the FIFO is full.
- R2: Let the raw trigger first be sampled high f clock edges after the most recent strobe edge, with 0 <= f < PERIOD. Let a be the sample delivered at that strobe and b the next one. Each channel of the logged word is then a + trunc((b - a) * f / PERIOD), in signed arithmetic that truncates toward zero. Channel c occupies bits [c*DW +: DW].
- R3: The logged word is written into the FIFO on the second clock edge after the strobe edge that delivers b. After that edge the waiting state is clear, unless a new trigger was taken.
- R4: Only a low-to-high change of `trig_in` counts as a trigger. Holding the input high across several sample periods gives exactly one logged word.
- R5: A trigger detected while another trigger is still waiting for its closing sample is discarded, and `trig_overrun` goes high and stays high until reset. A trigger detected in the same cycle as the closing sample is taken, and it does not set the flag.
- R6: When a result is ready and the FIFO is full, the push is blocked. The stored entries are unchanged, and `fifo_overflow` goes high and stays high until reset.
- R7: The FIFO returns words in the order they were written, and its head is visible on `fifo_dout` while `fifo_empty` is low. `pop` takes effect on the clock edge where it is high. A `pop` while the FIFO is empty has no effect.
- R8: After reset, `fifo_empty` is 1, `fifo_full` is 0, both sticky flags are 0, and `live_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the phase timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe marking a new filtered sample on every channel |
| smp_data | input | NCH*DW | Filtered samples, signed, channel c at [c*DW +: DW] |
| trig_in | input | 1 | Asynchronous user trigger, active on its rising edge |
| pop | input | 1 | Removes the FIFO head |
| live_data | output | NCH*DW | Latest filtered sample of every channel |
| fifo_dout | output | NCH*DW | FIFO head: interpolated word for one trigger |
| fifo_empty | output | 1 | FIFO holds no word |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| trig_overrun | output | 1 | Sticky: a trigger was discarded while another was waiting |
| fifo_overflow | output | 1 | Sticky: a result was discarded because the FIFO was full |

## Verification
The bench builds the block with two 8-bit channels, eight clocks per sample period and a four-word FIFO. With these values every trigger phase in the period can be swept against several sample pairs, including full-scale swings in both directions, and each expected word is computed arithmetically. The short period also makes it cheap to place triggers on the strobe cycle itself and two triggers in one period. Five triggers without a pop are enough to fill the small FIFO and run it into overflow, then drain it in order.

// File: rtl/trig_interp_pkg.sv
package trig_interp_pkg;

  // Wide signed working type for the interpolation arithmetic.
  localparam int ACC_W = 48;
  typedef logic signed [ACC_W-1:0] acc_t;

  // Point on the line from a to b at phase f out of n steps, truncating toward zero.
  function automatic acc_t lerp(input acc_t a, input acc_t b, input acc_t f, input acc_t n);
    acc_t span;
    acc_t scaled;
    span   = b - a;
    scaled = span * f;
    return a + (scaled / n);
  endfunction

  // Bit width needed to index v items, never below one.
  function automatic int bits_for(input int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/trig_interp_sync.sv
module trig_interp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      last  <= chain[STAGES-1];
    end
  end

  // One-cycle pulse, STAGES cycles after the raw edge was first sampled.
  assign rise = chain[STAGES-1] & ~last;

endmodule

// File: rtl/trig_interp_align.sv
module trig_interp_align
  import trig_interp_pkg::*;
#(
  parameter int W      = 32,
  parameter int LAT    = 2,
  parameter int PERIOD = 100,
  localparam int PW    = bits_for(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_in,
  input  logic [W-1:0]  data_in,
  output logic          stb_out,
  output logic [W-1:0]  data_out,
  output logic [PW-1:0] phase
);

  logic [LAT-1:0] stb_sr;
  logic [W-1:0]   dat_sr [LAT];
  logic [PW-1:0]  cnt;

  // Strobe and data held back by the synchronizer latency.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_sr <= '0;
      for (int i = 0; i < LAT; i++) dat_sr[i] <= '0;
    end else begin
      stb_sr[0] <= stb_in;
      dat_sr[0] <= data_in;
      for (int i = 1; i < LAT; i++) begin
        stb_sr[i] <= stb_sr[i-1];
        dat_sr[i] <= dat_sr[i-1];
      end
    end
  end

  // Clocks since the delayed strobe, saturating at the last phase of a period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (stb_out) begin
      cnt <= PW'(1);
    end else if (cnt != PW'(PERIOD - 1)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign stb_out  = stb_sr[LAT-1];
  assign data_out = dat_sr[LAT-1];
  assign phase    = stb_out ? '0 : cnt;

endmodule

// File: rtl/trig_interp_fifo.sv
module trig_interp_fifo
  import trig_interp_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = bits_for(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] count;
  logic          do_push;
  logic          do_pop;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout = mem[rd_ptr];

endmodule

// File: rtl/trig_interp.sv
module trig_interp
  import trig_interp_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int DW          = 16,
  parameter int PERIOD      = 100,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int W          = NCH * DW,
  localparam int PW         = bits_for(PERIOD)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_stb,
  input  logic [W-1:0] smp_data,
  input  logic         trig_in,
  input  logic         pop,
  output logic [W-1:0] live_data,
  output logic [W-1:0] fifo_dout,
  output logic         fifo_empty,
  output logic         fifo_full,
  output logic         trig_overrun,
  output logic         fifo_overflow
);

  localparam acc_t STEPS = acc_t'(PERIOD);

  // Named internal events, observed by the bound checker.
  logic          trig_rise;
  logic          stb_d;
  logic [W-1:0]  data_d;
  logic [PW-1:0] ph;
  logic          pend;
  logic          accept_evt;
  logic          drop_evt;
  logic          cmp_evt;
  logic          push_evt;

  logic [PW-1:0] f_q;
  logic [W-1:0]  base_q;
  logic [W-1:0]  cur_q;
  logic [W-1:0]  lerp_w;
  logic [W-1:0]  live_q;
  logic          overrun_q;
  logic          overflow_q;

  // One channel of the interpolation, trimmed back to the sample width.
  function automatic logic [DW-1:0] lerp_ch(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                            input logic [PW-1:0] f);
    acc_t r;
    r = lerp(acc_t'($signed(a)), acc_t'($signed(b)), acc_t'(f), STEPS);
    return r[DW-1:0];
  endfunction

  trig_interp_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (trig_in),
    .rise     (trig_rise)
  );

  trig_interp_align #(
    .W      (W),
    .LAT    (SYNC_STAGES),
    .PERIOD (PERIOD)
  ) u_align (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb_in   (smp_stb),
    .data_in  (smp_data),
    .stb_out  (stb_d),
    .data_out (data_d),
    .phase    (ph)
  );

  // A waiting trigger is closed by the delayed strobe; a new one is taken when
  // nothing waits or when the old one closes in the same cycle.
  assign cmp_evt    = pend & stb_d;
  assign accept_evt = trig_rise & (~pend | stb_d);
  assign drop_evt   = trig_rise & pend & ~stb_d;
  assign push_evt   = cmp_evt & ~fifo_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      f_q    <= '0;
      base_q <= '0;
      cur_q  <= '0;
    end else begin
      if (stb_d) cur_q <= data_d;
      if (accept_evt) begin
        pend   <= 1'b1;
        f_q    <= ph;
        base_q <= stb_d ? data_d : cur_q;
      end else if (stb_d) begin
        pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun_q  <= 1'b0;
      overflow_q <= 1'b0;
    end else begin
      if (drop_evt)              overrun_q  <= 1'b1;
      if (cmp_evt && fifo_full)  overflow_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       live_q <= '0;
    else if (smp_stb) live_q <= smp_data;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign lerp_w[c*DW +: DW] = lerp_ch(base_q[c*DW +: DW], data_d[c*DW +: DW], f_q);
  end

  trig_interp_fifo #(
    .W     (W),
    .DEPTH (DEPTH)
  ) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_evt),
    .din   (lerp_w),
    .pop   (pop),
    .dout  (fifo_dout),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  assign live_data     = live_q;
  assign trig_overrun  = overrun_q;
  assign fifo_overflow = overflow_q;

endmodule

// File: rtl/trig_interp_chk.sv
module trig_interp_chk #(
  parameter int NCH    = 4,
  parameter int DW     = 16,
  parameter int PERIOD = 100,
  parameter int PW     = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_stb,
  input logic [NCH*DW-1:0] smp_data,
  input logic [NCH*DW-1:0] live_data,
  input logic              trig_rise,
  input logic              stb_d,
  input logic [PW-1:0]     ph,
  input logic              pend,
  input logic              cmp_evt,
  input logic              push_evt,
  input logic              pop,
  input logic              fifo_empty,
  input logic              fifo_full,
  input logic              trig_overrun,
  input logic              fifo_overflow
);

  p_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> live_data == $past(smp_data));

  p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb_d |-> ph == '0);

  p_push_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt && !fifo_full |=> !fifo_empty);

  p_pend_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt && !trig_rise |=> !pend);

  p_rise_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise |=> !trig_rise);

  p_drop_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise && pend && !stb_d |=> trig_overrun);

  p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_overrun |=> trig_overrun);

  p_no_push_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt && fifo_full && !pop |=> fifo_full && fifo_overflow);

  p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_overflow |=> fifo_overflow);

  p_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty && pop && !push_evt |=> fifo_empty);

endmodule

bind trig_interp trig_interp_chk #(
  .NCH    (NCH),
  .DW     (DW),
  .PERIOD (PERIOD),
  .PW     (PW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .smp_stb       (smp_stb),
  .smp_data      (smp_data),
  .live_data     (live_data),
  .trig_rise     (trig_rise),
  .stb_d         (stb_d),
  .ph            (ph),
  .pend          (pend),
  .cmp_evt       (cmp_evt),
  .push_evt      (push_evt),
  .pop           (pop),
  .fifo_empty    (fifo_empty),
  .fifo_full     (fifo_full),
  .trig_overrun  (trig_overrun),
  .fifo_overflow (fifo_overflow)
);

// File: tb/trig_interp_bench.sv
module trig_interp_bench;

  localparam int NCH = 2;
  localparam int DW  = 8;
  localparam int P   = 8;
  localparam int DEP = 4;
  localparam int W   = NCH * DW;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         smp_stb = 1'b0;
  logic [W-1:0] smp_data = '0;
  logic         trig_in = 1'b0;
  logic         pop = 1'b0;
  logic [W-1:0] live_data;
  logic [W-1:0] fifo_dout;
  logic         fifo_empty;
  logic         fifo_full;
  logic         trig_overrun;
  logic         fifo_overflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench-side model of the logged path.
  logic [W-1:0] mq[$];
  bit           m_pend = 1'b0;
  int           m_f = 0;
  logic [W-1:0] m_base = '0;
  bit           m_lvl = 1'b0;
  bit           m_ovr = 1'b0;
  bit           m_ovf = 1'b0;
  bit           snap_e2;
  bit           snap_e3;

  trig_interp #(
    .NCH (NCH), .DW (DW), .PERIOD (P), .DEPTH (DEP)
  ) u_trig_interp (
    .clk (clk), .rst_n (rst_n), .smp_stb (smp_stb), .smp_data (smp_data),
    .trig_in (trig_in), .pop (pop), .live_data (live_data), .fifo_dout (fifo_dout),
    .fifo_empty (fifo_empty), .fifo_full (fifo_full),
    .trig_overrun (trig_overrun), .fifo_overflow (fifo_overflow)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected word: per channel a + (b-a)*f/P, integer division toward zero.
  function automatic logic [W-1:0] expect_word(input logic [W-1:0] a, input logic [W-1:0] b, input int f);
    logic [W-1:0] r;
    for (int c = 0; c < NCH; c++) begin
      int av = $signed(a[c*DW +: DW]);
      int bv = $signed(b[c*DW +: DW]);
      int v  = av + ((bv - av) * f) / P;
      r[c*DW +: DW] = DW'(v);
    end
    return r;
  endfunction

  function automatic logic [W-1:0] make_smp(input int seed);
    return {8'((seed * 91 + 200) % 256), 8'((seed * 53 + 17) % 256)};
  endfunction

  // One sample period: strobe at step 0, trigger level from mask, optional pop.
  task automatic interval(input logic [W-1:0] smp, input int mask, input bit do_pop, input string tag);
    bit ovr_at_start;
    ovr_at_start = m_ovr;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      if (i == 1) chk("R1 live value", live_data, smp);
      if (i == 2) snap_e2 = fifo_empty;
      if (i == 3) begin
        snap_e3 = fifo_empty;
        chk("R7 empty flag", W'(fifo_empty), W'(mq.size() == 0));
        chk("R6 full flag", W'(fifo_full), W'(mq.size() == DEP));
        chk("R6 overflow flag", W'(fifo_overflow), W'(m_ovf));
        chk("R5 overrun flag", W'(trig_overrun), W'(ovr_at_start));
      end
      if (i == 4 && do_pop && mq.size() != 0) begin
        chk(tag, fifo_dout, mq[0]);
        void'(mq.pop_front());
      end
      smp_stb = (i == 0);
      if (i == 0) smp_data = smp;
      trig_in = mask[i];
      pop = (i == 4) && do_pop;
      if (i == 0 && m_pend) begin
        if (mq.size() < DEP) mq.push_back(expect_word(m_base, smp, m_f));
        else m_ovf = 1'b1;
        m_pend = 1'b0;
      end
      if (mask[i] && !m_lvl) begin
        if (m_pend) m_ovr = 1'b1;
        else begin
          m_pend = 1'b1;
          m_f = i;
          m_base = smp;
        end
      end
      m_lvl = mask[i];
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset empty", W'(fifo_empty), W'(1));
    chk("R8 reset full", W'(fifo_full), W'(0));
    chk("R8 reset overrun", W'(trig_overrun), W'(0));
    chk("R8 reset overflow", W'(fifo_overflow), W'(0));
    chk("R8 reset live", live_data, '0);
    rst_n = 1'b1;
    interval(make_smp(999), 0, 1'b0, "R7 order");

    // R2 and R3: every phase against several sample pairs, including full scale.
    for (int k = 0; k < P; k++) begin
      for (int p = 0; p < 4; p++) begin
        logic [W-1:0] a = (p == 3) ? {8'h80, 8'h7f} : make_smp(k * 8 + p);
        logic [W-1:0] b = (p == 3) ? {8'h7f, 8'h80} : make_smp(k * 8 + p + 100);
        interval(a, 1 << k, 1'b0, "R2 interpolated word");
        interval(b, 0, 1'b1, "R2 interpolated word");
        chk("R3 not written before second edge", W'(snap_e2), W'(1));
        chk("R3 written at second edge", W'(snap_e3), W'(0));
      end
    end

    // R4: level held high across two periods logs one word only.
    interval(make_smp(11), 'hFC, 1'b0, "R4 held trigger");
    interval(make_smp(12), 'hFF, 1'b1, "R4 held trigger");
    interval(make_smp(13), 0, 1'b1, "R4 held trigger");
    interval(make_smp(14), 0, 1'b0, "R4 held trigger");
    chk("R4 single word from held trigger", W'(fifo_empty), W'(1));

    // R5: trigger on the closing strobe cycle is taken, no overrun.
    interval(make_smp(21), 1 << 3, 1'b0, "R5 coincident trigger");
    interval(make_smp(22), 1 << 0, 1'b1, "R5 coincident trigger");
    interval(make_smp(23), 0, 1'b1, "R5 coincident trigger");
    interval(make_smp(24), 0, 1'b0, "R5 coincident trigger");
    chk("R5 no overrun on coincident trigger", W'(trig_overrun), W'(0));

    // R5: second trigger in the same period is discarded.
    interval(make_smp(31), (1 << 1) | (1 << 5), 1'b0, "R5 first trigger kept");
    interval(make_smp(32), 0, 1'b1, "R5 first trigger kept");
    interval(make_smp(33), 0, 1'b0, "R5 first trigger kept");
    chk("R5 overrun set", W'(trig_overrun), W'(1));

    // R6: five results into a four-word FIFO.
    for (int n = 0; n < 5; n++) interval(make_smp(40 + n), 1 << (n + 2), 1'b0, "R6 fill");
    interval(make_smp(50), 0, 1'b0, "R6 fill");
    interval(make_smp(51), 0, 1'b0, "R6 fill");
    chk("R6 overflow set", W'(fifo_overflow), W'(1));
    chk("R6 still full", W'(fifo_full), W'(1));

    // R7: drain in order, then pop on empty, then one more word.
    for (int n = 0; n < DEP; n++) interval(make_smp(60 + n), 0, 1'b1, "R7 order");
    interval(make_smp(70), 0, 1'b1, "R7 pop on empty");
    chk("R7 empty after drain", W'(fifo_empty), W'(1));
    interval(make_smp(71), 1 << 6, 1'b0, "R7 after empty pop");
    interval(make_smp(72), 0, 1'b1, "R7 after empty pop");
    interval(make_smp(73), 0, 1'b0, "R7 after empty pop");
    chk("R7 empty at end", W'(fifo_empty), W'(1));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule